// File: doc/BRIEF.md
# Transmit Retry and Collision Controller

This block decides how many times a frame is put on a half-duplex medium. A frame is opened with a start strobe. From then on each attempt is bracketed by an attempt-begin strobe and an attempt-close strobe. A collision input seen at any point inside that bracket marks the attempt as collided. When an attempt closes, the block does one of three things:

- it asks for another try;
- it gives up with a retry error;
- it reports success.

Each outcome is a registered one-cycle pulse.

A single mode bit selects one of two policies. The first is one-shot transmission. The second is up to sixteen attempts, with the head of the frame held in the transmit FIFO so that it can be sent again. The same bit therefore also drives the FIFO-protect level. A second mode bit forces a collision on every attempt, so that the retry-error path can be exercised. It takes effect only when loopback is reported active at frame start. Backoff timing and the data path belong to neighbouring blocks.

Top module: `tx_retry_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it, retry_req, retry_err, done and fifo_protect are all 0.
- R2: One_shot, force_coll and loopback are sampled only on the clock that accepts frame_start. Later changes have no effect until the next frame.
- R3: With one_shot=1 at frame start, exactly one attempt is made. A collided attempt gives retry_err=1 and done=1 together, and retry_req never rises.
- R4: With one_shot=0, collided attempts 1 to 15 each give a retry_req pulse and no done. The 16th collided attempt gives retry_err=1 and done=1.
- R5: fifo_protect is 1 from the cycle after a frame is accepted with one_shot=0 until the cycle in which done rises. It is 0 throughout when one_shot=1.
- R6: An attempt that sees no collision gives done=1 with retry_err=0. The next frame counts its attempts from one again.
- R7: With force_coll=1 and loopback=1 at frame start, every attempt counts as collided, so the frame ends in a retry error after its attempt limit.
- R8: With force_coll=1 but loopback=0 at frame start, force_coll is ignored, and an attempt with no collision succeeds.
- R9: A collision seen in any cycle from the cycle after attempt_start is accepted up to the cycle of attempt_end counts for that attempt. A collision outside an attempt is ignored.
- R10: frame_start while a frame is open, and attempt_end while no attempt is open, are ignored. The attempt count is not reset and no pulse is produced.
- R11: retry_req, retry_err and done are single-cycle pulses that appear on the clock after the clock that samples attempt_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| one_shot | input | 1 | 1: single attempt per frame, 0: retries enabled |
| force_coll | input | 1 | Force a collision on every attempt (loopback test) |
| loopback | input | 1 | Internal loopback is active |
| frame_start | input | 1 | Open a new frame (accepted only when idle) |
| attempt_start | input | 1 | An attempt begins |
| attempt_end | input | 1 | The current attempt finishes |
| collision | input | 1 | Collision seen on the medium |
| retry_req | output | 1 | Pulse: retransmit after backoff |
| retry_err | output | 1 | Pulse: attempt limit exhausted |
| done | output | 1 | Pulse: frame finished (success or error) |
| fifo_protect | output | 1 | Hold the frame head in the transmit FIFO |

## Verification
Every outcome pulse is due exactly one clock after the edge that samples attempt_end. fifo_protect changes one clock after the edge that accepts frame_start, and falls on the same clock on which done rises. The driver stamps each expected outcome with its due cycle, taken from a free-running cycle count, and pushes it into a queue. The monitor compares on the falling edge of that cycle, so a pulse that comes a cycle early, comes a cycle late or does not come at all is caught. fifo_protect is checked at falling edges one clock after frame start and one clock after each attempt closes.

// File: rtl/tx_retry_pkg.sv
package tx_retry_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TX   = 2'd2
  } ctl_state_t;

  typedef enum logic [1:0] {
    V_RETRY   = 2'd0,
    V_SUCCESS = 2'd1,
    V_GIVEUP  = 2'd2
  } verdict_t;

  // Attempts allowed for one frame under the chosen policy.
  function automatic int attempt_limit(input logic single, input int max_att);
    return single ? 1 : max_att;
  endfunction

  // Outcome of an attempt, given whether it collided and how many attempts
  // have now been spent.
  function automatic verdict_t judge(input logic hit, input int spent, input int limit);
    if (!hit)
      return V_SUCCESS;
    if (spent >= limit)
      return V_GIVEUP;
    return V_RETRY;
  endfunction

endpackage

// File: rtl/txr_mode_latch.sv
module txr_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic single_in,
  input  logic force_in,
  input  logic loop_in,
  output logic single_q,
  output logic force_eff_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      single_q    <= 1'b0;
      force_eff_q <= 1'b0;
    end else if (capture) begin
      single_q    <= single_in;
      force_eff_q <= force_in & loop_in;
    end
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> ($stable(single_q) && $stable(force_eff_q)));

endmodule

// File: rtl/txr_attempt_counter.sv
module txr_attempt_counter #(
  parameter int MAX_ATTEMPTS = 16,
  localparam int CNT_W = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             incr,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clear)
      count <= '0;
    else if (incr && (int'(count) < MAX_ATTEMPTS))
      count <= count + 1'b1;
  end

  // R4
  cnt_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= MAX_ATTEMPTS);

endmodule

// File: rtl/txr_collision_watch.sv
module txr_collision_watch (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic in_attempt,
  input  logic collision,
  output logic seen_q
);

  always_ff @(posedge clk) begin
    if (rst || arm)
      seen_q <= 1'b0;
    else if (in_attempt && collision)
      seen_q <= 1'b1;
  end

  // R9
  seen_only_in_attempt_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_attempt && !arm) |=> (seen_q == $past(seen_q)));

endmodule

// File: rtl/tx_retry_ctrl.sv
module tx_retry_ctrl #(
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic one_shot,
  input  logic force_coll,
  input  logic loopback,
  input  logic frame_start,
  input  logic attempt_start,
  input  logic attempt_end,
  input  logic collision,
  output logic retry_req,
  output logic retry_err,
  output logic done,
  output logic fifo_protect
);
  import tx_retry_pkg::*;

  localparam int CNT_W = $clog2(MAX_ATTEMPTS + 1);

  ctl_state_t state_q, state_d;
  logic [CNT_W-1:0] attempts;
  logic single_q, force_eff_q, coll_seen_q;

  // Named internal events
  logic     frame_accept, attempt_begin, attempt_close, hit, finish;
  int       limit;
  verdict_t verdict;

  assign frame_accept  = (state_q == ST_IDLE) && frame_start;
  assign attempt_begin = (state_q == ST_WAIT) && attempt_start;
  assign attempt_close = (state_q == ST_TX) && attempt_end;
  assign hit           = coll_seen_q | collision | force_eff_q;
  assign limit         = attempt_limit(single_q, MAX_ATTEMPTS);
  assign verdict       = judge(hit, int'(attempts) + 1, limit);
  assign finish        = attempt_close && (verdict != V_RETRY);

  txr_mode_latch u_mode (
    .clk         (clk),
    .rst         (rst),
    .capture     (frame_accept),
    .single_in   (one_shot),
    .force_in    (force_coll),
    .loop_in     (loopback),
    .single_q    (single_q),
    .force_eff_q (force_eff_q)
  );

  txr_attempt_counter #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (frame_accept),
    .incr  (attempt_close),
    .count (attempts)
  );

  txr_collision_watch u_coll (
    .clk        (clk),
    .rst        (rst),
    .arm        (attempt_begin),
    .in_attempt (state_q == ST_TX),
    .collision  (collision),
    .seen_q     (coll_seen_q)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (frame_accept)  state_d = ST_WAIT;
      ST_WAIT: if (attempt_begin) state_d = ST_TX;
      ST_TX:   if (attempt_close) state_d = finish ? ST_IDLE : ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      retry_req    <= 1'b0;
      retry_err    <= 1'b0;
      done         <= 1'b0;
      fifo_protect <= 1'b0;
    end else begin
      state_q   <= state_d;
      retry_req <= attempt_close && (verdict == V_RETRY);
      retry_err <= attempt_close && (verdict == V_GIVEUP);
      done      <= finish;
      if (frame_accept)
        fifo_protect <= !one_shot;
      else if (finish)
        fifo_protect <= 1'b0;
    end
  end

  // R3
  single_no_retry_chk: assert property (@(posedge clk) disable iff (rst)
    (single_q && state_q != ST_IDLE) |=> !retry_req);

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    retry_err |-> done);

  // R11
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  req_excl_done_chk: assert property (@(posedge clk) disable iff (rst)
    !(retry_req && done));

  // R5
  protect_policy_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_protect |-> (!single_q && state_q != ST_IDLE));

  // R5
  protect_drop_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !fifo_protect);

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && state_q != ST_IDLE) |=> $stable(single_q));

endmodule

// File: tb/tx_retry_ctrl_tb.sv
module tx_retry_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic one_shot = 0, force_coll = 0, loopback = 0;
  logic frame_start = 0, attempt_start = 0, attempt_end = 0, collision = 0;
  logic retry_req, retry_err, done, fifo_protect;

  always #10 clk = ~clk;

  tx_retry_ctrl dut_i (
    .clk(clk), .rst(rst), .one_shot(one_shot), .force_coll(force_coll),
    .loopback(loopback), .frame_start(frame_start), .attempt_start(attempt_start),
    .attempt_end(attempt_end), .collision(collision), .retry_req(retry_req),
    .retry_err(retry_err), .done(done), .fifo_protect(fifo_protect)
  );

  typedef struct {
    int    due;
    bit    req;
    bit    err;
    bit    dn;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  // Bench model of the open frame
  int tb_limit = 16;
  int tb_spent = 0;
  bit tb_forced = 0;
  bit tb_single = 0;
  bit tb_open = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Monitor: compares outcome pulses against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst) begin
      while (exp_q.size() > 0 && exp_q[0].due < cyc) begin
        check(0, {exp_q[0].tag, " missing"}, 0, 1);
        void'(exp_q.pop_front());
      end
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        check({retry_req, retry_err, done} == {e.req, e.err, e.dn}, e.tag,
              int'({retry_req, retry_err, done}), int'({e.req, e.err, e.dn}));
      end else if (retry_req || retry_err || done) begin
        check(0, "R10 unexpected pulse", int'({retry_req, retry_err, done}), 0);
      end
    end
  end

  task automatic start_frame(input bit single, input bit frc, input bit lb);
    @(negedge clk);
    one_shot = single; force_coll = frc; loopback = lb; frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    tb_single = single; tb_limit = single ? 1 : 16; tb_spent = 0;
    tb_forced = frc & lb; tb_open = 1;
    check(fifo_protect == !single, "R5 protect after start", int'(fifo_protect), int'(!single));
  endtask

  // where: 0 no collision, 1 collision mid-attempt, 2 collision at close
  task automatic attempt(input int where, input string tag);
    exp_t e;
    bit hitb;
    attempt_start = 1;
    @(negedge clk);
    attempt_start = 0; collision = (where == 1);
    @(negedge clk);
    collision = (where == 2); attempt_end = 1;
    hitb = (where != 0) || tb_forced;
    tb_spent++;
    e.due = cyc + 1; e.tag = tag;
    e.req = hitb && (tb_spent < tb_limit);
    e.err = hitb && (tb_spent >= tb_limit);
    e.dn  = !e.req;
    exp_q.push_back(e);
    if (e.dn) tb_open = 0;
    @(negedge clk);
    attempt_end = 0; collision = 0;
    check(fifo_protect == (tb_open && !tb_single), {tag, " R5 protect"},
          int'(fifo_protect), int'(tb_open && !tb_single));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({retry_req, retry_err, done, fifo_protect} == 4'b0, "R1 in reset",
          int'({retry_req, retry_err, done, fifo_protect}), 0);
    rst = 0;
    @(negedge clk);
    check({retry_req, retry_err, done, fifo_protect} == 4'b0, "R1 after reset",
          int'({retry_req, retry_err, done, fifo_protect}), 0);

    // R6 success on first try, retries enabled
    start_frame(0, 0, 0);
    attempt(0, "R6 first-try success");

    // R4 three collisions then success (R6 count restarts next frame)
    start_frame(0, 0, 0);
    for (int i = 0; i < 3; i++) attempt(2, "R4 retry request");
    attempt(0, "R6 success after retries");

    // R4 sixteen collisions -> retry error
    start_frame(0, 0, 0);
    for (int i = 0; i < 16; i++) attempt(2, "R4 limit of sixteen");

    // R3 one-shot collision -> immediate error
    start_frame(1, 0, 0);
    attempt(2, "R3 one-shot collision");
    start_frame(1, 0, 0);
    attempt(0, "R3 one-shot success");

    // R7 forced collision in loopback
    start_frame(0, 1, 1);
    for (int i = 0; i < 16; i++) attempt(0, "R7 forced in loopback");
    start_frame(1, 1, 1);
    attempt(0, "R7 forced one-shot");

    // R8 forced without loopback is ignored
    start_frame(0, 1, 0);
    attempt(0, "R8 force ignored");

    // R2 mode change mid-frame has no effect
    start_frame(0, 0, 0);
    one_shot = 1; force_coll = 1; loopback = 1;
    attempt(2, "R2 held retry mode");
    attempt(0, "R2 held no force");
    one_shot = 0; force_coll = 0; loopback = 0;

    // R9 collision outside an attempt ignored, mid-attempt counted
    start_frame(0, 0, 0);
    collision = 1;
    @(negedge clk);
    collision = 0;
    attempt(1, "R9 mid-attempt collision");
    collision = 1;
    @(negedge clk);
    collision = 0;
    attempt(0, "R9 outside collision ignored");

    // R10 frame_start while busy, attempt_end while no attempt open
    start_frame(0, 0, 0);
    for (int i = 0; i < 15; i++) attempt(2, "R10 fill attempts");
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    attempt_end = 1;
    @(negedge clk);
    attempt_end = 0;
    @(negedge clk);
    check(done == 0 && retry_err == 0, "R10 stray attempt_end", int'(done), 0);
    attempt(2, "R10 count kept");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule